// File: doc/BRIEF.md
# Pluggable Module Management Controller

This block is the low-speed control logic on the module side of a pluggable optical transceiver. It takes three host pins: an active-low select, an active-low reset and an active-high low-power request. It also takes a simple register read/write strobe port of the kind a 2-wire serial slave would drive. From these it decides whether the serial slave may answer the bus. It runs the reset and initialization sequence and keeps the data-not-ready status bit. It drives the active-low, open-drain style interrupt level. It also works out the effective power mode.

The sequencer has three states. `ST_INIT` counts the initialization time, and the data-not-ready bit is 1 there. `ST_RUN` is normal operation. `ST_HOLD` means a valid reset pulse has been recognised and the reset pin is still low. Transitions:
- power-up → `ST_INIT`
- `ST_INIT` → `ST_RUN` when the init count expires (done)
- `ST_INIT` or `ST_RUN` → `ST_HOLD` when the reset pin has stayed low long enough (trigger)
- `ST_HOLD` → `ST_INIT` when the reset pin is seen high again (release)

Each entry into `ST_RUN` arms a reset-complete interrupt. The host clears it by reading the status byte and the flag byte. Flag events are latched and also pull the interrupt low.

Register map used by the host: status byte at address 2 (bit 0 = data-not-ready), latched flag byte at address 3, power-control byte at address 93.

Top module: `modmgmt_ctrl`

## Requirements
- R1: While the synchronized select pin is high, `bus_resp_en` is 0, writes have no effect and reads leave `reg_rdata` unchanged. Out of power-up reset the select is taken as high (deselected).
- R2: When the reset pin has been low for at least `MIN_RST` consecutive synchronized samples, the block performs a full reset. The power-control byte returns to 0, latched flags clear, any pending interrupt is released (`int_n` = 1), and data-not-ready becomes 1.
- R3: A reset-pin low pulse of `MIN_RST`-1 or fewer samples has no effect. The status byte still reads 0 and the power-control byte keeps its value.
- R4: Initialization is timed from the release of the reset pin. Data-not-ready stays 1 for as long as the pin is held low, and clears `INIT_CYC` cycles after the release is seen.
- R5: While data-not-ready is 1, a read of address 2 returns 0x01 and reads of addresses 3 and 93 return 0x00. Writes are ignored.
- R6: When initialization ends, data-not-ready clears and `int_n` goes low in the same cycle. This also happens after power-up reset with no reset-pin pulse.
- R7: A pending reset-complete interrupt is released only after both a status read (address 2, bit 0 = 0) and a flag read (address 3) have occurred since it was armed. The two reads may come in either order. One read alone keeps `int_n` low.
- R8: A 1 on `flag_evt[i]` in run state sets bit i of the flag byte at address 3. A flag read returns the byte and clears it, except for events present in that same cycle. `int_n` is low while any latched flag is 1.
- R9: Power-control byte bit 0 is override, bit 1 is power set, and bit 2 is high-power-class enable. `low_power` equals bit 1 when override is 1 and equals the synchronized low-power pin otherwise. `hi_class_ok` = !`low_power` && bit 2.
- R10: Every host pin passes through a two-flop synchronizer that resets high. A pin change reaches the outputs on the second clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low |
| sel_n_pin | input | 1 | Host module select, active low |
| rst_pin_n | input | 1 | Host module reset, active low |
| lpm_pin | input | 1 | Host low-power request, active high |
| reg_rd | input | 1 | Register read strobe from the serial slave |
| reg_wr | input | 1 | Register write strobe from the serial slave |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| flag_evt | input | NFLAG | Flag source events, one per flag bit |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after a read strobe |
| bus_resp_en | output | 1 | Serial slave may acknowledge and respond |
| int_n | output | 1 | Interrupt level, 0 = drive low |
| low_power | output | 1 | Effective low-power state |
| hi_class_ok | output | 1 | High-power classes allowed |

## Verification
A sequencer stuck in the wrong state is visible on the status byte: a read of address 2 returns the wrong bit 0 one cycle after the strobe. The same fault usually shows on `int_n` within a cycle of the expected init-done edge. A wrong interrupt-tracking bit shows as `int_n` rising after a single read, or staying low after both. The bench compares the outputs against its own model every cycle, so such a fault is seen on the first clock where the outputs differ. A power-control fault shows on `low_power` or `hi_class_ok` directly after the write, and a synchronizer fault shifts every pin response by a cycle.

// File: rtl/modmgmt_pkg.sv
package modmgmt_pkg;
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } mm_state_e;

    localparam logic [7:0] ADDR_STATUS = 8'd2;
    localparam logic [7:0] ADDR_FLAGS  = 8'd3;
    localparam logic [7:0] ADDR_PWR    = 8'd93;

    localparam int PWR_OVR = 0;
    localparam int PWR_SET = 1;
    localparam int PWR_HPC = 2;
endpackage

// File: rtl/mm_sync.sv
module mm_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
    import modmgmt_pkg::*;
#(
    parameter int MIN_RST  = 16,
    parameter int INIT_CYC = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rstp_s,
    output mm_state_e state,
    output logic      dnr,
    output logic      clr,
    output logic      done
);
    localparam int LW = $clog2(MIN_RST + 1);
    localparam int IW = $clog2(INIT_CYC + 1);

    mm_state_e       state_nx;
    logic [LW-1:0]   low_cnt;
    logic [IW-1:0]   init_cnt;
    logic            trig;
    logic            init_end;

    assign trig     = !rstp_s && (low_cnt == LW'(MIN_RST - 1));
    assign init_end = (init_cnt == IW'(INIT_CYC - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: if (trig) state_nx = ST_HOLD;
                     else if (init_end) state_nx = ST_RUN;
            ST_RUN:  if (trig) state_nx = ST_HOLD;
            ST_HOLD: if (rstp_s) state_nx = ST_INIT;
            default: state_nx = ST_INIT;
        endcase
    end

    // state register and its timing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_INIT;
            low_cnt  <= '0;
            init_cnt <= '0;
        end else begin
            state <= state_nx;
            if (rstp_s)
                low_cnt <= '0;
            else if (low_cnt != LW'(MIN_RST - 1))
                low_cnt <= low_cnt + 1'b1;
            init_cnt <= (state == ST_INIT) ? init_cnt + 1'b1 : '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        dnr  = 1'b1;
        clr  = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_INIT: done = init_end && !trig;
            ST_RUN:  dnr  = 1'b0;
            ST_HOLD: clr  = 1'b1;
            default: dnr  = 1'b1;
        endcase
    end
endmodule

// File: rtl/mm_irq.sv
module mm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic done,
    input  logic stat_rd,
    input  logic flag_rd,
    output logic pend
);
    logic seen_stat, seen_flag;
    logic stat_nx, flag_nx;

    assign stat_nx = seen_stat || stat_rd;
    assign flag_nx = seen_flag || flag_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            seen_stat <= 1'b0;
            seen_flag <= 1'b0;
        end else if (clr) begin
            pend      <= 1'b0;
            seen_stat <= 1'b0;
            seen_flag <= 1'b0;
        end else if (done) begin
            pend      <= 1'b1;
            seen_stat <= 1'b0;
            seen_flag <= 1'b0;
        end else if (pend) begin
            if (stat_nx && flag_nx) begin
                pend      <= 1'b0;
                seen_stat <= 1'b0;
                seen_flag <= 1'b0;
            end else begin
                seen_stat <= stat_nx;
                seen_flag <= flag_nx;
            end
        end
    end
endmodule

// File: rtl/modmgmt_ctrl.sv
module modmgmt_ctrl
    import modmgmt_pkg::*;
#(
    parameter int NFLAG    = 4,
    parameter int MIN_RST  = 16,
    parameter int INIT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_pin,
    input  logic             rst_pin_n,
    input  logic             lpm_pin,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [NFLAG-1:0] flag_evt,
    output logic [7:0]       reg_rdata,
    output logic             bus_resp_en,
    output logic             int_n,
    output logic             low_power,
    output logic             hi_class_ok
);
    logic [2:0]       pins_s;
    logic             sel_s, rstp_s, lpm_s;
    mm_state_e        seq_state;
    logic             seq_dnr, seq_clr, seq_done;
    logic             rd_ok, wr_ok, stat_rd, flag_rd, rc_pend;
    logic [7:0]       pwr_q;
    logic [NFLAG-1:0] flags_q;

    mm_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sel_n_pin, rst_pin_n, lpm_pin}),
        .q(pins_s)
    );
    assign {sel_s, rstp_s, lpm_s} = pins_s;

    mm_seq #(.MIN_RST(MIN_RST), .INIT_CYC(INIT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .rstp_s(rstp_s),
        .state(seq_state), .dnr(seq_dnr), .clr(seq_clr), .done(seq_done)
    );

    assign bus_resp_en = !sel_s;
    assign rd_ok   = reg_rd && bus_resp_en;
    assign wr_ok   = reg_wr && bus_resp_en && !seq_dnr;
    assign stat_rd = rd_ok && !seq_dnr && (reg_addr == ADDR_STATUS);
    assign flag_rd = rd_ok && !seq_dnr && (reg_addr == ADDR_FLAGS);

    mm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .clr(seq_clr), .done(seq_done),
        .stat_rd(stat_rd), .flag_rd(flag_rd), .pend(rc_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q     <= '0;
            flags_q   <= '0;
            reg_rdata <= '0;
        end else begin
            if (seq_clr)
                pwr_q <= '0;
            else if (wr_ok && reg_addr == ADDR_PWR)
                pwr_q <= reg_wdata;

            if (seq_dnr)
                flags_q <= '0;
            else
                flags_q <= (flag_rd ? '0 : flags_q) | flag_evt;

            if (rd_ok) begin
                unique case (reg_addr)
                    ADDR_STATUS: reg_rdata <= {7'b0, seq_dnr};
                    ADDR_FLAGS:  reg_rdata <= seq_dnr ? 8'h00 : 8'(flags_q);
                    ADDR_PWR:    reg_rdata <= seq_dnr ? 8'h00 : pwr_q;
                    default:     reg_rdata <= 8'h00;
                endcase
            end
        end
    end

    assign int_n       = !(rc_pend || (|flags_q));
    assign low_power   = pwr_q[PWR_OVR] ? pwr_q[PWR_SET] : lpm_s;
    assign hi_class_ok = !low_power && pwr_q[PWR_HPC];
endmodule

// File: rtl/mm_chk.sv
module mm_chk
    import modmgmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       int_n,
    input logic       reg_wr,
    input logic       bus_resp_en,
    input logic       low_power,
    input logic       lpm_s,
    input logic       rstp_s,
    input logic       dnr,
    input logic       clr,
    input logic       stat_rd,
    input logic       flag_rd,
    input mm_state_e  state,
    input logic [7:0] pwr
);
    // R1
    desel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_resp_en && !clr && reg_wr) |=> $stable(pwr));

    // R3
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && rstp_s) |=> (state == ST_RUN));

    // R4
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rstp_s) |=> (state == ST_HOLD));

    // R5
    dnr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dnr && !clr && reg_wr) |=> $stable(pwr));

    // R6
    done_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dnr) |-> !int_n);

    // R7
    int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !dnr && !stat_rd && !flag_rd) |=> !int_n);

    // R9
    lp_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dnr && !clr) |-> (low_power == lpm_s));
endmodule

bind modmgmt_ctrl mm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .reg_wr(reg_wr),
    .bus_resp_en(bus_resp_en), .low_power(low_power), .lpm_s(lpm_s),
    .rstp_s(rstp_s), .dnr(seq_dnr), .clr(seq_clr), .stat_rd(stat_rd),
    .flag_rd(flag_rd), .state(seq_state), .pwr(pwr_q)
);

// File: tb/modmgmt_ctrl_test.sv
module modmgmt_ctrl_test;
    localparam int NF = 4;
    localparam int MR = 4;
    localparam int IC = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          sel_n_pin = 1, rst_pin_n = 1, lpm_pin = 1;
    logic          reg_rd = 0, reg_wr = 0;
    logic [7:0]    reg_addr = 0, reg_wdata = 0;
    logic [NF-1:0] flag_evt = 0;
    logic [7:0]    reg_rdata;
    logic          bus_resp_en, int_n, low_power, hi_class_ok;

    int checks = 0, failures = 0;
    bit finished = 0;

    modmgmt_ctrl #(.NFLAG(NF), .MIN_RST(MR), .INIT_CYC(IC)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_sel1, m_sel2, m_rp1, m_rp2, m_lp1, m_lp2;
    int m_st, m_low, m_ic, m_pwr, m_flags, m_rdata, m_pend, m_ss, m_sf;
    int t_dnr, t_clr, t_trig, t_done, t_rd, t_wr, t_srd, t_frd, t_nst;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel1 = 1; m_sel2 = 1; m_rp1 = 1; m_rp2 = 1; m_lp1 = 1; m_lp2 = 1;
            m_st = 0; m_low = 0; m_ic = 0; m_pwr = 0; m_flags = 0; m_rdata = 0;
            m_pend = 0; m_ss = 0; m_sf = 0;
        end else begin
            t_dnr  = (m_st != 1);
            t_clr  = (m_st == 2);
            t_trig = (m_rp2 == 0) && (m_low == MR - 1);
            t_done = (m_st == 0) && !t_trig && (m_ic == IC - 1);
            t_rd   = reg_rd && (m_sel2 == 0);
            t_wr   = reg_wr && (m_sel2 == 0) && !t_dnr;
            t_srd  = t_rd && !t_dnr && (reg_addr == 2);
            t_frd  = t_rd && !t_dnr && (reg_addr == 3);
            if (t_rd) begin
                if (reg_addr == 2) m_rdata = t_dnr;
                else if (reg_addr == 3) m_rdata = t_dnr ? 0 : m_flags;
                else if (reg_addr == 93) m_rdata = t_dnr ? 0 : m_pwr;
                else m_rdata = 0;
            end
            if (t_clr) m_pwr = 0;
            else if (t_wr && reg_addr == 93) m_pwr = reg_wdata;
            if (t_dnr) m_flags = 0;
            else m_flags = (t_frd ? 0 : m_flags) | flag_evt;
            if (t_clr) begin m_pend = 0; m_ss = 0; m_sf = 0; end
            else if (t_done) begin m_pend = 1; m_ss = 0; m_sf = 0; end
            else if (m_pend == 1) begin
                m_ss = m_ss | t_srd;
                m_sf = m_sf | t_frd;
                if (m_ss == 1 && m_sf == 1) begin m_pend = 0; m_ss = 0; m_sf = 0; end
            end
            t_nst = m_st;
            if (m_st == 0) begin if (t_trig) t_nst = 2; else if (t_done) t_nst = 1; end
            else if (m_st == 1) begin if (t_trig) t_nst = 2; end
            else if (m_rp2 == 1) t_nst = 0;
            m_ic  = (m_st == 0) ? m_ic + 1 : 0;
            m_low = (m_rp2 == 1) ? 0 : ((m_low == MR - 1) ? m_low : m_low + 1);
            m_st  = t_nst;
            m_sel2 = m_sel1; m_sel1 = sel_n_pin;
            m_rp2  = m_rp1;  m_rp1  = rst_pin_n;
            m_lp2  = m_lp1;  m_lp1  = lpm_pin;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 model bus_resp_en", bus_resp_en, (m_sel2 == 0));
            chk("R7 model int_n", int_n, !(m_pend == 1 || m_flags != 0));
            chk("R5 model reg_rdata", reg_rdata, m_rdata);
            chk("R9 model low_power", low_power,
                ((m_pwr & 1) != 0) ? ((m_pwr >> 1) & 1) : m_lp2);
            chk("R9 model hi_class_ok", hi_class_ok,
                (!low_power) && (((m_pwr >> 2) & 1) != 0));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        tick(3);
        rst_n = 1;
        @(negedge clk);
        chk("R1 deselected after power-up", bus_resp_en, 0);
        chk("R10 low-power pin default high", low_power, 1);
        chk("R6 int released during init", int_n, 1);
        sel_n_pin = 0;
        tick(1);
        wr(8'd93, 8'h07);
        rd(8'd2, v);
        chk("R5 status reads 1 during init", v, 1);
        tick(8);
        chk("R6 power-up reset-complete interrupt", int_n, 0);
        rd(8'd93, v);
        chk("R5 write during init ignored", v, 0);
        rd(8'd2, v);
        chk("R7 status read shows ready", v, 0);
        tick(2);
        chk("R7 status read alone keeps int low", int_n, 0);
        rd(8'd3, v);
        chk("R7 flag read returns empty", v, 0);
        chk("R7 both reads release int", int_n, 1);

        // R8 flag latch and clear
        @(negedge clk); flag_evt = 4'b0010;
        @(negedge clk); flag_evt = 0;
        tick(2);
        chk("R8 latched flag pulls int low", int_n, 0);
        rd(8'd3, v);
        chk("R8 flag byte value", v, 2);
        chk("R8 flag read clears and releases", int_n, 1);
        @(negedge clk); reg_rd = 1; reg_addr = 8'd3; flag_evt = 4'b1000;
        @(negedge clk); reg_rd = 0; flag_evt = 0;
        chk("R8 same-cycle event survives read", int_n, 0);
        rd(8'd3, v);
        chk("R8 same-cycle event latched", v, 8);

        // R9 power mode
        lpm_pin = 0;
        wr(8'd93, 8'h00);
        tick(2);
        chk("R9 pin low, no override", low_power, 0);
        chk("R9 hpc disabled", hi_class_ok, 0);
        wr(8'd93, 8'h04);
        chk("R9 hpc enabled", hi_class_ok, 1);
        lpm_pin = 1;
        wr(8'd93, 8'h05);
        tick(2);
        chk("R9 override with set 0", low_power, 0);
        chk("R9 override allows hpc", hi_class_ok, 1);
        wr(8'd93, 8'h07);
        chk("R9 override with set 1", low_power, 1);
        chk("R9 low power blocks hpc", hi_class_ok, 0);

        // R10 synchronizer latency and R1 deselect
        @(negedge clk); sel_n_pin = 1;
        @(negedge clk);
        chk("R10 one edge not enough", bus_resp_en, 1);
        @(negedge clk);
        chk("R10 two edges", bus_resp_en, 0);
        wr(8'd93, 8'h00);
        rd(8'd2, v);
        chk("R1 read while deselected keeps rdata", v, 8);
        sel_n_pin = 0;
        tick(3);
        rd(8'd93, v);
        chk("R1 write while deselected ignored", v, 7);

        // R3 short reset pulse
        @(negedge clk); rst_pin_n = 0;
        tick(MR - 1);
        rst_pin_n = 1;
        tick(6);
        rd(8'd2, v);
        chk("R3 short pulse no reset", v, 0);
        rd(8'd93, v);
        chk("R3 settings kept", v, 7);

        // R2 / R4 full reset
        @(negedge clk); flag_evt = 4'b0001;
        @(negedge clk); flag_evt = 0; rst_pin_n = 0;
        tick(1);
        chk("R2 flag int before reset", int_n, 0);
        tick(20);
        rd(8'd2, v);
        chk("R4 still not ready while held", v, 1);
        chk("R2 int released by reset", int_n, 1);
        chk("R2 power settings defaulted", low_power, 1);
        rst_pin_n = 1;
        tick(3);
        rd(8'd2, v);
        chk("R4 init timed from release", v, 1);
        chk("R4 no interrupt yet", int_n, 1);
        tick(10);
        chk("R6 reset-complete interrupt", int_n, 0);
        rd(8'd2, v);
        chk("R4 ready after init", v, 0);
        rd(8'd93, v);
        chk("R2 power byte cleared", v, 0);
        rd(8'd3, v);
        chk("R7 release after reset", int_n, 1);

        tick(2);
        finished = 1;
        summary();
        $finish;
    end
endmodule